// File: doc/BRIEF.md
# PCI Type 0 Configuration Header Register File

This block holds the 64-byte Type 0 configuration header of one PCI function. An access port carries a byte offset, an access size, a read/write flag and write data. The block answers each access on the following clock edge with registered read data and an error flag. Identification, class and interrupt-routing fields are fixed by parameters. Command, cache line size, latency timer, interrupt line, the expansion ROM register and six base address registers can be written.

Each base address register has a power-of-two decode size set by a parameter. Address bits below that size cannot be set, so a probe write of all ones reads back as the size mask. The low type bits of a BAR keep their reset value. For every BAR the block also drives a decoded base address, which is the BAR's address bits plus a fixed I/O or memory window offset. Alongside it are a valid flag and a one-cycle pulse that fires whenever any BAR's address bits change. These let a neighbouring decoder rebuild its routing tables.

Top module: `pcfg_header_regs`

## Requirements
- R1: `acc_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. The value 3 sets `acc_err` on the next cycle with `acc_rdata` = 0, and leaves every register unchanged.
- R2: An access whose last byte lies at offset 0x40 or above sets `acc_err` with `acc_rdata` = 0 and updates nothing. This covers both a start at or above 0x40 and a multi-byte access that crosses it.
- R3: Reads are little-endian. Byte lane n of `acc_rdata` holds header byte offset+n, and unused upper lanes read zero. Read data and error appear on the clock edge that samples `acc_valid`, and a write returns `acc_rdata` = 0.
- R4: Only a dword write at a BAR offset (0x10 + 4·i, i = 0..5) updates that BAR. Its address bits take the write data ANDed with ~(size−1). Writing 0xFFFFFFFF therefore reads back ~(size−1) above the type bits, and a size-0 BAR keeps a zero address.
- R5: A BAR write never alters the type bits. These are bits [1:0] when bit 0 is 1 (I/O), and bits [3:0] otherwise (memory).
- R6: `bar_base[32·i +: 32]` equals BAR i's address bits plus `IO_WIN` (I/O BAR) or `MEM_WIN` (memory BAR). `bar_valid[i]` is 1 exactly when those address bits are non-zero.
- R7: A dword write of 0xFFFFFFFE at offset 0x30 makes the ROM register read 0xFFFFFFFF. Any other dword write there is stored as written.
- R8: Byte writes at 0x0C (cache line size), 0x0D (latency timer) and 0x3C (interrupt line) store the byte. Word or dword writes covering them do not.
- R9: Writes to vendor/device ID (0x00), revision and class (0x08), interrupt pin (0x3D), minimum grant and maximum latency have no effect.
- R10: A dword write at 0x04 loads the command register (bits [15:0]) from `acc_wdata[15:0]`. The status half (bits [31:16]) keeps its value.
- R11: Reset loads every field from its parameter default and clears every BAR address to zero, leaving only the type bit (1 for I/O BARs).
- R12: `range_change` is high for one cycle, the cycle after a BAR write that changes that BAR's address bits. A BAR write that leaves the address bits as they were produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | 0 byte, 1 word, 2 dword, 3 invalid |
| acc_offset | input | 8 | Byte offset into the header |
| acc_wdata | input | 32 | Write data, little-endian lanes |
| acc_rdata | output | 32 | Registered read data |
| acc_err | output | 1 | Registered error flag for the sampled access |
| bar_base | output | 192 | Six decoded base addresses, BAR i at bits 32·i+31 : 32·i |
| bar_valid | output | 6 | Decoded range valid per BAR |
| range_change | output | 1 | One-cycle pulse after a BAR address change |

## Verification
The decoded-base outputs and the change pulse are the hardest part to reach. A BAR only shows a valid range after a dword write whose bits survive both the size mask and the type mask. The change pulse needs a rewrite that alters the masked address, which ordinary writes cannot trigger on their own. The stimulus therefore probes each BAR with all ones, then writes values whose low bits fall below the size mask. It then rewrites one BAR first with an identical masked address, which must give no pulse, and then with a different one, which must give a single pulse. Unaligned reads, offsets that cross the end of the header, and the reserved size code are driven as their own vectors.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

    localparam int DW         = 32;
    localparam int NUM_BARS   = 6;
    localparam int HDR_BYTES  = 64;
    localparam int HDR_DWORDS = HDR_BYTES / 4;

    localparam logic [7:0] OFS_CMD  = 8'h04;
    localparam logic [7:0] OFS_CLS  = 8'h0C;
    localparam logic [7:0] OFS_LAT  = 8'h0D;
    localparam logic [7:0] OFS_BAR0 = 8'h10;
    localparam logic [7:0] OFS_ROM  = 8'h30;
    localparam logic [7:0] OFS_INTL = 8'h3C;

    localparam logic [DW-1:0] ROM_PROBE = 32'hFFFF_FFFE;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_BAD   = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic                err;
        logic                cmd;
        logic                cls;
        logic                lat;
        logic                intl;
        logic                rom;
        logic [NUM_BARS-1:0] bar;
    } wr_dec_t;

    function automatic logic [3:0] size_bytes(acc_size_e s);
        case (s)
            SZ_BYTE:  return 4'd1;
            SZ_WORD:  return 4'd2;
            SZ_DWORD: return 4'd4;
            default:  return 4'd0;
        endcase
    endfunction

    function automatic logic [DW-1:0] lane_mask(acc_size_e s);
        case (s)
            SZ_BYTE:  return 32'h0000_00FF;
            SZ_WORD:  return 32'h0000_FFFF;
            SZ_DWORD: return 32'hFFFF_FFFF;
            default:  return 32'h0;
        endcase
    endfunction

    function automatic logic [DW-1:0] type_mask(logic is_io);
        return is_io ? 32'h0000_0003 : 32'h0000_000F;
    endfunction

endpackage

// File: rtl/pcfg_acc_decode.sv
module pcfg_acc_decode
    import pcfg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      acc_valid,
    input  logic      acc_write,
    input  acc_size_e acc_size,
    input  logic [7:0] acc_offset,
    output wr_dec_t   dec
);

    logic [8:0] end_ofs;
    logic       bad;

    always_comb begin
        end_ofs = {1'b0, acc_offset} + {5'b0, size_bytes(acc_size)};
        bad     = (acc_size == SZ_BAD) || (end_ofs > 9'(HDR_BYTES));
        dec     = '0;
        dec.err = acc_valid && bad;
        if (acc_valid && acc_write && !bad) begin
            case (acc_size)
                SZ_BYTE: begin
                    dec.cls  = (acc_offset == OFS_CLS);
                    dec.lat  = (acc_offset == OFS_LAT);
                    dec.intl = (acc_offset == OFS_INTL);
                end
                SZ_DWORD: begin
                    dec.cmd = (acc_offset == OFS_CMD);
                    dec.rom = (acc_offset == OFS_ROM);
                    for (int i = 0; i < NUM_BARS; i++)
                        dec.bar[i] = (acc_offset == OFS_BAR0 + 8'(4 * i));
                end
                default: ;
            endcase
        end
    end

    // An erroring access must select no writable target (R2)
    assert_err_no_write_R2: assert property (@(posedge clk) disable iff (rst)
        dec.err |-> ({dec.cmd, dec.cls, dec.lat, dec.intl, dec.rom, dec.bar} == '0));

    // At most one register is written per access (R9)
    assert_single_target_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dec.cmd, dec.cls, dec.lat, dec.intl, dec.rom, dec.bar}));

endmodule

// File: rtl/pcfg_bar.sv
module pcfg_bar
    import pcfg_pkg::*;
#(
    parameter logic [31:0] SIZE    = 32'h0000_1000,
    parameter bit          IS_IO   = 1'b0,
    parameter logic [31:0] IO_WIN  = 32'h1000_0000,
    parameter logic [31:0] MEM_WIN = 32'h4000_0000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] bar_q,
    output logic [DW-1:0] base,
    output logic          valid,
    output logic          changed
);

    localparam logic [DW-1:0] SZMASK  = ~(SIZE - 32'd1);
    localparam logic [DW-1:0] TMASK   = IS_IO ? 32'h3 : 32'hF;
    localparam logic [DW-1:0] RST_VAL = IS_IO ? 32'h1 : 32'h0;

    logic [DW-1:0] tm, nxt, addr;

    always_comb begin
        tm   = type_mask(bar_q[0]);
        nxt  = ((wdata & SZMASK) & ~tm) | (bar_q & tm);
        addr = bar_q & ~tm;
        base = addr + (bar_q[0] ? IO_WIN : MEM_WIN);
        valid = (addr != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bar_q   <= RST_VAL;
            changed <= 1'b0;
        end else begin
            changed <= wr_en && ((nxt & ~tm) != addr);
            if (wr_en)
                bar_q <= nxt;
        end
    end

    // An all-ones probe leaves the size mask in the address bits (R4)
    assert_probe_mask_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en && (wdata == 32'hFFFF_FFFF) |=> ((bar_q & ~TMASK) == (SZMASK & ~TMASK)));

    // Type bits survive every write (R5)
    assert_type_kept_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((bar_q & TMASK) == ($past(bar_q) & TMASK)));

    // A range becomes valid only as a result of a write (R6)
    assert_valid_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> $past(wr_en));

    // A change pulse always follows a write (R12)
    assert_pulse_cause_R12: assert property (@(posedge clk) disable iff (rst)
        changed |-> $past(wr_en));

endmodule

// File: rtl/pcfg_header_regs.sv
module pcfg_header_regs
    import pcfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID     = 16'h1A2B,
    parameter logic [15:0] DEVICE_ID     = 16'h3C4D,
    parameter logic [15:0] CMD_INIT      = 16'h0000,
    parameter logic [15:0] STATUS_INIT   = 16'h0290,
    parameter logic [7:0]  REVISION      = 8'h05,
    parameter logic [23:0] CLASS_CODE    = 24'h020000,
    parameter logic [7:0]  CLS_INIT      = 8'h00,
    parameter logic [7:0]  LAT_INIT      = 8'h00,
    parameter logic [7:0]  HEADER_TYPE   = 8'h00,
    parameter logic [7:0]  BIST_VAL      = 8'h00,
    parameter logic [31:0] CARDBUS_PTR   = 32'h0,
    parameter logic [15:0] SUBSYS_VENDOR = 16'h1A2B,
    parameter logic [15:0] SUBSYS_ID     = 16'h0001,
    parameter logic [31:0] ROM_INIT      = 32'h0,
    parameter logic [7:0]  INTL_INIT     = 8'h0B,
    parameter logic [7:0]  INT_PIN       = 8'h01,
    parameter logic [7:0]  MIN_GNT       = 8'h02,
    parameter logic [7:0]  MAX_LAT       = 8'h03,
    parameter logic [NUM_BARS-1:0][31:0] BAR_SIZE =
        {32'h0, 32'h0, 32'h0, 32'h0010_0000, 32'h0000_0100, 32'h0000_1000},
    parameter logic [NUM_BARS-1:0] BAR_IO = 6'b000010,
    parameter logic [31:0] IO_WIN  = 32'h1000_0000,
    parameter logic [31:0] MEM_WIN = 32'h4000_0000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   acc_valid,
    input  logic                   acc_write,
    input  logic [1:0]             acc_size,
    input  logic [7:0]             acc_offset,
    input  logic [31:0]            acc_wdata,
    output logic [31:0]            acc_rdata,
    output logic                   acc_err,
    output logic [NUM_BARS*32-1:0] bar_base,
    output logic [NUM_BARS-1:0]    bar_valid,
    output logic                   range_change
);

    localparam int BAR_DW0 = int'(OFS_BAR0) / 4;

    acc_size_e     sz;
    wr_dec_t       dec;
    logic [15:0]   cmd_q;
    logic [7:0]    cls_q, lat_q, intl_q;
    logic [31:0]   rom_q;
    logic [31:0]   bar_val [NUM_BARS];
    logic [NUM_BARS-1:0] bar_chg;
    logic [31:0]   hdr [HDR_DWORDS];
    logic [3:0]    idx;
    logic [63:0]   pair;
    logic [31:0]   rd;

    assign sz = acc_size_e'(acc_size);

    pcfg_acc_decode u_dec (
        .clk        (clk),
        .rst        (rst),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_size   (sz),
        .acc_offset (acc_offset),
        .dec        (dec)
    );

    for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
        pcfg_bar #(
            .SIZE    (BAR_SIZE[i]),
            .IS_IO   (BAR_IO[i]),
            .IO_WIN  (IO_WIN),
            .MEM_WIN (MEM_WIN)
        ) u_bar (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (dec.bar[i]),
            .wdata   (acc_wdata),
            .bar_q   (bar_val[i]),
            .base    (bar_base[32*i +: 32]),
            .valid   (bar_valid[i]),
            .changed (bar_chg[i])
        );
    end

    assign range_change = |bar_chg;

    always_comb begin
        for (int d = 0; d < HDR_DWORDS; d++)
            hdr[d] = '0;
        hdr[0]  = {DEVICE_ID, VENDOR_ID};
        hdr[1]  = {STATUS_INIT, cmd_q};
        hdr[2]  = {CLASS_CODE, REVISION};
        hdr[3]  = {BIST_VAL, HEADER_TYPE, lat_q, cls_q};
        for (int b = 0; b < NUM_BARS; b++)
            hdr[BAR_DW0 + b] = bar_val[b];
        hdr[10] = CARDBUS_PTR;
        hdr[11] = {SUBSYS_ID, SUBSYS_VENDOR};
        hdr[12] = rom_q;
        hdr[15] = {MAX_LAT, MIN_GNT, INT_PIN, intl_q};

        idx  = acc_offset[5:2];
        pair = {(idx == 4'd15) ? 32'h0 : hdr[idx + 4'd1], hdr[idx]};
        pair = pair >> {acc_offset[1:0], 3'b000};
        rd   = pair[31:0] & lane_mask(sz);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_rdata <= '0;
            acc_err   <= 1'b0;
            cmd_q     <= CMD_INIT;
            cls_q     <= CLS_INIT;
            lat_q     <= LAT_INIT;
            intl_q    <= INTL_INIT;
            rom_q     <= ROM_INIT;
        end else begin
            acc_err   <= dec.err;
            acc_rdata <= (acc_valid && !acc_write && !dec.err) ? rd : '0;
            if (dec.cmd)  cmd_q  <= acc_wdata[15:0];
            if (dec.cls)  cls_q  <= acc_wdata[7:0];
            if (dec.lat)  lat_q  <= acc_wdata[7:0];
            if (dec.intl) intl_q <= acc_wdata[7:0];
            if (dec.rom)  rom_q  <= (acc_wdata == ROM_PROBE) ? 32'hFFFF_FFFF : acc_wdata;
        end
    end

    // Reserved size code flags an error and returns zero (R1)
    assert_bad_size_R1: assert property (@(posedge clk) disable iff (rst)
        acc_valid && (acc_size == 2'd3) |=> acc_err && (acc_rdata == 32'h0));

    // Probe value on the ROM register reads back as all ones (R7)
    assert_rom_probe_R7: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_write && (acc_size == 2'd2) && (acc_offset == OFS_ROM)
        && (acc_wdata == ROM_PROBE) |=> (rom_q == 32'hFFFF_FFFF));

    // Interrupt line only moves on a byte write to its offset (R8)
    assert_intl_byte_R8: assert property (@(posedge clk) disable iff (rst)
        !(acc_valid && acc_write && (acc_size == 2'd0) && (acc_offset == OFS_INTL))
        |=> $stable(intl_q));

    // Command register only moves on a dword write at its offset (R10)
    assert_cmd_dword_R10: assert property (@(posedge clk) disable iff (rst)
        !(acc_valid && acc_write && (acc_size == 2'd2) && (acc_offset == OFS_CMD))
        |=> $stable(cmd_q));

endmodule

// File: tb/pcfg_header_regs_tb_top.sv
`timescale 1ns/1ps
module pcfg_header_regs_tb_top;

    typedef struct packed {
        logic        wr;
        logic [1:0]  sz;
        logic [7:0]  ofs;
        logic [31:0] wd;
        logic [31:0] exp;
        logic        err;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 45;
    localparam logic [1:0] B = 2'd0, W = 2'd1, D = 2'd2, X = 2'd3;

    localparam vec_t VEC [NV] = '{
        '{1'b0, D, 8'h00, 32'h0,        32'h3C4D1A2B, 1'b0, 8'd3},  // R3 dword
        '{1'b0, B, 8'h01, 32'h0,        32'h0000001A, 1'b0, 8'd3},  // R3 byte lane
        '{1'b0, W, 8'h02, 32'h0,        32'h00003C4D, 1'b0, 8'd3},  // R3 word
        '{1'b0, W, 8'h01, 32'h0,        32'h00004D1A, 1'b0, 8'd3},  // R3 unaligned
        '{1'b0, D, 8'h3C, 32'h0,        32'h0302010B, 1'b0, 8'd11}, // R11 defaults
        '{1'b0, D, 8'h3D, 32'h0,        32'h0,        1'b1, 8'd2},  // R2 crossing
        '{1'b0, B, 8'h40, 32'h0,        32'h0,        1'b1, 8'd2},  // R2 beyond
        '{1'b0, X, 8'h00, 32'h0,        32'h0,        1'b1, 8'd1},  // R1 bad size
        '{1'b1, B, 8'h0C, 32'h10,       32'h0,        1'b0, 8'd8},  // R8
        '{1'b0, B, 8'h0C, 32'h0,        32'h00000010, 1'b0, 8'd8},
        '{1'b1, B, 8'h0D, 32'h40,       32'h0,        1'b0, 8'd8},
        '{1'b0, D, 8'h0C, 32'h0,        32'h00004010, 1'b0, 8'd8},
        '{1'b1, W, 8'h0C, 32'hFFFF,     32'h0,        1'b0, 8'd8},  // R8 word ignored
        '{1'b0, D, 8'h0C, 32'h0,        32'h00004010, 1'b0, 8'd8},
        '{1'b1, B, 8'h3C, 32'h05,       32'h0,        1'b0, 8'd8},
        '{1'b1, B, 8'h3D, 32'hFF,       32'h0,        1'b0, 8'd9},  // R9 pin RO
        '{1'b0, D, 8'h3C, 32'h0,        32'h03020105, 1'b0, 8'd9},
        '{1'b1, D, 8'h00, 32'hFFFFFFFF, 32'h0,        1'b0, 8'd9},  // R9 ids RO
        '{1'b0, D, 8'h00, 32'h0,        32'h3C4D1A2B, 1'b0, 8'd9},
        '{1'b1, D, 8'h04, 32'hFFFF0007, 32'h0,        1'b0, 8'd10}, // R10
        '{1'b0, D, 8'h04, 32'h0,        32'h02900007, 1'b0, 8'd10},
        '{1'b1, D, 8'h10, 32'hFFFFFFFF, 32'h0,        1'b0, 8'd4},  // R4 probe
        '{1'b0, D, 8'h10, 32'h0,        32'hFFFFF000, 1'b0, 8'd4},
        '{1'b1, D, 8'h10, 32'h80001234, 32'h0,        1'b0, 8'd4},
        '{1'b0, D, 8'h10, 32'h0,        32'h80001000, 1'b0, 8'd4},
        '{1'b1, D, 8'h14, 32'hFFFFFFFF, 32'h0,        1'b0, 8'd5},  // R5 io
        '{1'b0, D, 8'h14, 32'h0,        32'hFFFFFF01, 1'b0, 8'd5},
        '{1'b1, D, 8'h14, 32'h0000C302, 32'h0,        1'b0, 8'd5},
        '{1'b0, D, 8'h14, 32'h0,        32'h0000C301, 1'b0, 8'd5},
        '{1'b1, D, 8'h18, 32'h1234567F, 32'h0,        1'b0, 8'd4},
        '{1'b0, D, 8'h18, 32'h0,        32'h12300000, 1'b0, 8'd4},
        '{1'b1, D, 8'h1C, 32'hFFFFFFFF, 32'h0,        1'b0, 8'd4},  // R4 size 0
        '{1'b0, D, 8'h1C, 32'h0,        32'h0,        1'b0, 8'd4},
        '{1'b1, D, 8'h30, 32'hFFFFFFFE, 32'h0,        1'b0, 8'd7},  // R7
        '{1'b0, D, 8'h30, 32'h0,        32'hFFFFFFFF, 1'b0, 8'd7},
        '{1'b1, D, 8'h30, 32'hABCD0001, 32'h0,        1'b0, 8'd7},
        '{1'b0, D, 8'h30, 32'h0,        32'hABCD0001, 1'b0, 8'd7},
        '{1'b1, X, 8'h0C, 32'hAA,       32'h0,        1'b1, 8'd1},  // R1 no update
        '{1'b0, B, 8'h0C, 32'h0,        32'h00000010, 1'b0, 8'd1},
        '{1'b1, B, 8'h08, 32'hFF,       32'h0,        1'b0, 8'd9},  // R9 revision
        '{1'b0, D, 8'h08, 32'h0,        32'h02000005, 1'b0, 8'd9},
        '{1'b1, W, 8'h10, 32'hFFFF,     32'h0,        1'b0, 8'd4},  // R4 word ignored
        '{1'b0, D, 8'h10, 32'h0,        32'h80001000, 1'b0, 8'd4},
        '{1'b1, D, 8'h3E, 32'h0,        32'h0,        1'b1, 8'd2},  // R2 no update
        '{1'b0, D, 8'h3C, 32'h0,        32'h03020105, 1'b0, 8'd2}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [1:0]  acc_size = 2'd0;
    logic [7:0]  acc_offset = 8'h0;
    logic [31:0] acc_wdata = 32'h0;
    logic [31:0] acc_rdata;
    logic        acc_err;
    logic [191:0] bar_base;
    logic [5:0]  bar_valid;
    logic        range_change;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pcfg_header_regs dut_i (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_size(acc_size), .acc_offset(acc_offset), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_err(acc_err), .bar_base(bar_base),
        .bar_valid(bar_valid), .range_change(range_change)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(logic wr, logic [1:0] sz, logic [7:0] ofs, logic [31:0] wd);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_size = sz;
        acc_offset = ofs; acc_wdata = wd;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state at the ports
        check("R11 rdata", acc_rdata, 32'h0);
        check("R11 err", {31'b0, acc_err}, 32'h0);
        check("R11 valid", {26'b0, bar_valid}, 32'h0);
        check("R11 pulse", {31'b0, range_change}, 32'h0);
        access(1'b0, D, 8'h14, 32'h0);
        check("R11 io bar", acc_rdata, 32'h00000001);

        for (int v = 0; v < NV; v++) begin
            access(VEC[v].wr, VEC[v].sz, VEC[v].ofs, VEC[v].wd);
            check($sformatf("R%0d vec%0d data", VEC[v].req, v), acc_rdata, VEC[v].exp);
            check($sformatf("R%0d vec%0d err", VEC[v].req, v), {31'b0, acc_err}, {31'b0, VEC[v].err});
        end

        // R6: decoded bases and valid flags
        check("R6 base0", bar_base[31:0],  32'hC0001000);
        check("R6 base1", bar_base[63:32], 32'h1000C300);
        check("R6 base2", bar_base[95:64], 32'h52300000);
        check("R6 valid", {26'b0, bar_valid}, 32'h00000007);

        // R12: identical masked address gives no pulse
        access(1'b1, D, 8'h18, 32'h12300ABC);
        check("R12 no pulse", {31'b0, range_change}, 32'h0);
        access(1'b1, D, 8'h18, 32'h22300000);
        check("R12 pulse", {31'b0, range_change}, 32'h1);
        @(negedge clk);
        check("R12 one cycle", {31'b0, range_change}, 32'h0);
        check("R6 base2 moved", bar_base[95:64], 32'h62300000);

        // R11: reset mid-run restores defaults
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R11 valid after rst", {26'b0, bar_valid}, 32'h0);
        access(1'b0, D, 8'h10, 32'h0);
        check("R11 bar0", acc_rdata, 32'h0);
        access(1'b0, D, 8'h0C, 32'h0);
        check("R11 cls", acc_rdata, 32'h0);
        access(1'b0, D, 8'h30, 32'h0);
        check("R11 rom", acc_rdata, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule